// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers interrupt causes from many sources into one status word and delivers them to a host. Each source requests service by presenting a raise strobe with a bit mask. Software services the requests by writing an acknowledge strobe with a mask of the bits it has handled. The `status` output is the word that software reads through its register decode.

The block has two delivery modes, chosen by a level input. When message interrupts are disabled, it drives a level-sensitive interrupt line. That line stays high until every pending bit has been acknowledged. When message interrupts are enabled, each raise that leaves work pending produces a single-cycle pulse. Logic outside this block turns that pulse into a bus message.

All three outputs are registered. A strobe presented before a clock edge shows up at the outputs just after that edge.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, `status` is zero and both `irqLine` and `msiPulse` are low.
- R2: A cycle with `raiseValid` high ORs `raiseMask` into `status`, visible after the next clock edge.
- R3: A cycle with `ackValid` high clears every bit of `status` that is set in `ackMask`. Unmasked bits are kept.
- R4: When raise and acknowledge arrive in the same cycle, a bit set in both masks ends up set. Bits set only in `ackMask` are cleared.
- R5: With `msiEnable` high, a raise that leaves `status` nonzero makes `msiPulse` high for exactly the following cycle. Such a raise does not change `irqLine`.
- R6: A pulse is issued for every qualifying raise, even if the raised bits were already set. Raises in consecutive cycles keep `msiPulse` high in each of the following cycles.
- R7: With `msiEnable` low, a raise that leaves `status` nonzero sets `irqLine` high and issues no pulse.
- R8: With `msiEnable` low, `irqLine` falls only on an acknowledge that leaves `status` zero. A partial acknowledge keeps it high.
- R9: With `msiEnable` high, an acknowledge that empties `status` leaves `irqLine` at its prior value.
- R10: A raise that leaves `status` zero (zero mask on an empty word) produces no pulse and no change on `irqLine`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| raiseValid | input | 1 | Raise strobe |
| raiseMask | input | WIDTH | Bits to set on a raise |
| ackValid | input | 1 | Acknowledge strobe |
| ackMask | input | WIDTH | Bits to clear on an acknowledge |
| msiEnable | input | 1 | 1 selects pulse delivery, 0 selects level delivery |
| status | output | WIDTH | Pending interrupt word, readable by software |
| irqLine | output | 1 | Level-sensitive interrupt line |
| msiPulse | output | 1 | One-cycle message interrupt request |

## Verification
The bench builds the block with its default width of 32. This lets the stimulus touch the most significant bit together with low bits, so bits at both ends of the word are checked through raise, acknowledge and overlap cases. Directed tasks switch `msiEnable` between events. This exercises the cases where the line holds its value, where the pulse repeats on already-set bits, and where a raise with an empty mask leaves everything unchanged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Control decisions for one cycle, passed to the datapath
  typedef struct packed {
    logic loadStatus;
    logic setLine;
    logic clrLine;
    logic firePulse;
  } aggStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic        raiseValid,
  input  logic        ackValid,
  input  logic        msiEnable,
  input  logic        nextIsZero,
  output aggStrobes_t strobes
);
  always_comb begin
    strobes            = '0;
    strobes.loadStatus = raiseValid | ackValid;
    // pulse mode: one pulse per raise that leaves work pending
    strobes.firePulse  = raiseValid & msiEnable & ~nextIsZero;
    // level mode: raise asserts, emptying acknowledge releases
    strobes.setLine    = raiseValid & ~msiEnable & ~nextIsZero;
    strobes.clrLine    = ackValid & ~msiEnable & nextIsZero;
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             raiseValid,
  input  logic [WIDTH-1:0] raiseMask,
  input  logic             ackValid,
  input  logic [WIDTH-1:0] ackMask,
  input  aggStrobes_t      strobes,
  output logic [WIDTH-1:0] status,
  output logic             nextIsZero,
  output logic             irqLine,
  output logic             msiPulse
);
  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] setBits;
  logic [WIDTH-1:0] clrBits;
  logic [WIDTH-1:0] nextStatus;

  always_comb begin
    setBits    = raiseValid ? raiseMask : ZERO_WORD;
    clrBits    = ackValid ? ackMask : ZERO_WORD;
    // clear first, then set: raise wins on overlap
    nextStatus = (status & ~clrBits) | setBits;
    nextIsZero = (nextStatus == ZERO_WORD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status   <= '0;
      irqLine  <= 1'b0;
      msiPulse <= 1'b0;
    end else begin
      if (strobes.loadStatus) status <= nextStatus;
      if (strobes.setLine) irqLine <= 1'b1;
      else if (strobes.clrLine) irqLine <= 1'b0;
      msiPulse <= strobes.firePulse;
    end
  end

  // R2
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    raiseValid |=> ((status & $past(raiseMask)) == $past(raiseMask)));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !raiseValid) |=> ((status & $past(ackMask)) == ZERO_WORD));

  // R6
  no_raise_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !raiseValid |=> !msiPulse);

  // R8
  line_falls_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqLine) |-> (status == ZERO_WORD));

  // R5
  pulse_keeps_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |-> $stable(irqLine));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             raiseValid,
  input  logic [WIDTH-1:0] raiseMask,
  input  logic             ackValid,
  input  logic [WIDTH-1:0] ackMask,
  input  logic             msiEnable,
  output logic [WIDTH-1:0] status,
  output logic             irqLine,
  output logic             msiPulse
);
  aggStrobes_t strobes;
  logic        nextIsZero;

  irq_agg_ctrl uCtrl (
    .raiseValid(raiseValid),
    .ackValid  (ackValid),
    .msiEnable (msiEnable),
    .nextIsZero(nextIsZero),
    .strobes   (strobes)
  );

  irq_agg_datapath #(.WIDTH(WIDTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .raiseValid(raiseValid),
    .raiseMask (raiseMask),
    .ackValid  (ackValid),
    .ackMask   (ackMask),
    .strobes   (strobes),
    .status    (status),
    .nextIsZero(nextIsZero),
    .irqLine   (irqLine),
    .msiPulse  (msiPulse)
  );
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         raiseValid = 1'b0;
  logic [W-1:0] raiseMask = '0;
  logic         ackValid = 1'b0;
  logic [W-1:0] ackMask = '0;
  logic         msiEnable = 1'b0;
  logic [W-1:0] status;
  logic         irqLine;
  logic         msiPulse;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  irq_status_agg #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .raiseValid(raiseValid), .raiseMask(raiseMask),
    .ackValid(ackValid), .ackMask(ackMask), .msiEnable(msiEnable),
    .status(status), .irqLine(irqLine), .msiPulse(msiPulse)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one event: drive at negedge, sample just after the next rising edge
  task automatic step(input logic r, input logic [W-1:0] rm,
                      input logic a, input logic [W-1:0] am);
    @(negedge clk);
    raiseValid = r; raiseMask = rm; ackValid = a; ackMask = am;
    @(posedge clk); #1;
    raiseValid = 1'b0; raiseMask = '0; ackValid = 1'b0; ackMask = '0;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, '0);
  endtask

  task automatic test_reset();
    check("R1 status", status, '0);
    check("R1 line", {31'b0, irqLine}, 32'd0);
    check("R1 pulse", {31'b0, msiPulse}, 32'd0);
  endtask

  task automatic test_level_raise();
    msiEnable = 1'b0;
    step(1'b1, 32'h0000_0005, 1'b0, '0);
    check("R2 status", status, 32'h0000_0005);
    check("R7 line", {31'b0, irqLine}, 32'd1);
    check("R7 pulse", {31'b0, msiPulse}, 32'd0);
    step(1'b1, 32'h8000_0000, 1'b0, '0);
    check("R2 top bit", status, 32'h8000_0005);
  endtask

  task automatic test_ack();
    step(1'b0, '0, 1'b1, 32'h0000_0001);
    check("R3 partial", status, 32'h8000_0004);
    check("R8 line held", {31'b0, irqLine}, 32'd1);
    step(1'b0, '0, 1'b1, 32'h8000_0004);
    check("R3 empty", status, '0);
    check("R8 line low", {31'b0, irqLine}, 32'd0);
  endtask

  task automatic test_overlap();
    step(1'b1, 32'h0000_00FF, 1'b0, '0);
    step(1'b1, 32'h0000_000F, 1'b1, 32'h0000_003C);
    check("R4 overlap", status, 32'h0000_00CF);
    step(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    check("R8 all clear", {31'b0, irqLine}, 32'd0);
  endtask

  task automatic test_msi();
    msiEnable = 1'b1;
    step(1'b1, 32'h0000_0002, 1'b0, '0);
    check("R5 pulse", {31'b0, msiPulse}, 32'd1);
    check("R5 line", {31'b0, irqLine}, 32'd0);
    idle();
    check("R5 one cycle", {31'b0, msiPulse}, 32'd0);
    step(1'b1, 32'h0000_0002, 1'b0, '0);
    check("R6 repeat", {31'b0, msiPulse}, 32'd1);
    @(negedge clk);
    raiseValid = 1'b1; raiseMask = 32'h0000_0010;
    @(posedge clk); #1;
    check("R6 b2b first", {31'b0, msiPulse}, 32'd1);
    @(posedge clk); #1;
    raiseValid = 1'b0; raiseMask = '0;
    check("R6 b2b second", {31'b0, msiPulse}, 32'd1);
    idle();
    check("R6 end", {31'b0, msiPulse}, 32'd0);
    check("R6 status", status, 32'h0000_0012);
  endtask

  task automatic test_hold();
    msiEnable = 1'b0;
    step(1'b1, 32'h0000_0001, 1'b0, '0);
    check("R7 line set", {31'b0, irqLine}, 32'd1);
    msiEnable = 1'b1;
    step(1'b0, '0, 1'b1, 32'hFFFF_FFFF);
    check("R9 status", status, '0);
    check("R9 line hold", {31'b0, irqLine}, 32'd1);
    msiEnable = 1'b0;
    step(1'b0, '0, 1'b1, '0);
    check("R8 release", {31'b0, irqLine}, 32'd0);
  endtask

  task automatic test_empty_raise();
    msiEnable = 1'b1;
    step(1'b1, '0, 1'b0, '0);
    check("R10 no pulse", {31'b0, msiPulse}, 32'd0);
    msiEnable = 1'b0;
    step(1'b1, '0, 1'b0, '0);
    check("R10 line", {31'b0, irqLine}, 32'd0);
    check("R10 status", status, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk);
    rstN = 1'b1;
    test_level_raise();
    test_ack();
    test_overlap();
    test_msi();
    test_hold();
    test_empty_raise();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule